// File: doc/BRIEF.md
# Dual-Channel Setting Register Serial Target

This block is the serial-bus target front end of a device that holds two 8-bit setting registers, for example the wiper codes of a two-channel digital potentiometer. It oversamples the bus clock and data lines with the system clock and detects START and STOP conditions. It compares the address byte against a fixed five-bit prefix plus two strap inputs and takes part in a transaction only when the whole seven-bit address matches. Open-drain behaviour is left to the pad. The block asks for a low level on the data line through a single pull-low output.

A write transaction carries an address byte, then a command byte, then any number of data bytes. The command byte chooses one of the two channels and sets two general-purpose logic outputs. Every data byte that follows overwrites the chosen channel. A read transaction returns the chosen channel straight after the address acknowledge, and keeps returning it for as long as the controller acknowledges. The channel choice persists between transactions, so a write that stops after the command byte is the way to pick which channel later reads return.

The control state machine has these states. IDLE waits for a START. ADDR shifts in the address byte. ADDR_ACK acknowledges a matching address. INSTR receives the command byte and INSTR_ACK acknowledges it. WR_BYTE receives a data byte and WR_ACK acknowledges it. RD_BYTE shifts out the selected register. RD_ACK samples the controller's acknowledge. SKIP stays silent until the next START or STOP. Transitions: START from any state goes to ADDR, and STOP from any state goes to IDLE. ADDR ends its byte in ADDR_ACK on a match and in SKIP otherwise. ADDR_ACK goes to INSTR when R/W is 0 and to RD_BYTE when R/W is 1. INSTR goes to INSTR_ACK. INSTR_ACK goes to WR_BYTE. WR_BYTE and WR_ACK alternate. RD_BYTE goes to RD_ACK. RD_ACK returns to RD_BYTE on an acknowledge and goes to SKIP on a not-acknowledge.

Top module: `twin_setting_i2c_target`

## Requirements
- R1: After reset both channel outputs read 0x80, both logic outputs are 0, channel 0 is selected, and the pull-low output is 0.
- R2: The block acknowledges an address byte only if it equals {01011, strap[1], strap[0], R/W}, sent MSB first. For any other address it never pulls the data line, and none of the following bytes change a register or a logic output.
- R3: For an accepted address, command or data byte in a write, the data line is pulled low for the whole ninth (acknowledge) clock. The pull-low output changes only while the bus clock is low.
- R4: In the command byte, bit 7 selects the channel (0 or 1), bit 4 sets logic output 1 and bit 3 sets logic output 2. Bits 6, 5 and 2..0 have no effect. Both logic outputs take their new values when the command byte completes and hold them until the next command byte.
- R5: Every data byte of a write transaction is stored into the channel that the command byte of that transaction selected. Further data bytes in the same transaction overwrite that channel again, and the other channel is left unchanged.
- R6: With R/W = 1 the block drives the selected channel's value MSB first, starting in the clock that follows the address acknowledge, with no command byte in between.
- R7: A write that ends after the command byte leaves both registers unchanged but still changes the channel that reads return.
- R8: During a read, a controller acknowledge causes the same register to be sent again in the next byte. A not-acknowledge makes the block release the line until the next START.
- R9: A STOP (data rising while the clock is high) returns the block to idle with the line released. Bytes clocked after a STOP without a new START are neither acknowledged nor acted on.
- R10: A repeated START in the middle of a transaction restarts address matching, so a write may be followed directly by a read of the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired value) |
| strap | input | 2 | Address strap levels, compared with address bits 2 and 1 |
| sda_pull_low | output | 1 | 1 requests the pad to pull the data line low |
| level_a | output | 8 | Channel 0 setting register |
| level_b | output | 8 | Channel 1 setting register |
| gpo_1 | output | 1 | Logic output 1 (command bit 4) |
| gpo_2 | output | 1 | Logic output 2 (command bit 3) |

## Verification
Writes go to each channel in turn. A command byte with its reserved and don't-care bits set checks that only bits 7, 4 and 3 matter. Repeated data bytes show whether a second byte lands on the same channel. A read after a command-only write returns the untouched channel and not the one written last, which shows whether the selection is tracked apart from the data. A wrong address, a strap change and bytes clocked with no START separate address matching from framing. A read that ends in an acknowledge and then a not-acknowledge, together with a repeated START from write into read, separates the continuation rules from restart handling.

// File: rtl/twsr_pkg.sv
package twsr_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_CH     = 2;
    localparam int STRAP_W    = 2;
    localparam int INS_CH_BIT = 7;
    localparam int INS_O1_BIT = 4;
    localparam int INS_O2_BIT = 3;
    localparam int NUM_LINES  = 2;
    localparam int LINE_SCL   = 0;
    localparam int LINE_SDA   = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/twsr_line_sync.sv
module twsr_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    // Each line: a chain of STAGES flops, then one more flop for edge detection.
    // Reset to 1 so that an idle (pulled-up) bus produces no edge after reset.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~last;
        assign fall[g] = ~chain[STAGES-1] & last;
    end
endmodule

// File: rtl/twsr_chan_bank.sv
module twsr_chan_bank
    import twsr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_LEVEL = 8'h80
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           instr_we,
    input  logic                           data_we,
    input  logic [BYTE_W-1:0]              wr_byte,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  level,
    output logic [1:0]                     gpo,
    output logic [BYTE_W-1:0]              rd_value
);
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SEL_W-1:0] sel_q;

    // Command register: channel select and the two logic outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            gpo   <= '0;
        end else if (instr_we) begin
            sel_q  <= wr_byte[INS_CH_BIT -: SEL_W];
            gpo[0] <= wr_byte[INS_O1_BIT];
            gpo[1] <= wr_byte[INS_O2_BIT];
        end
    end

    // One setting register per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                level[g] <= RESET_LEVEL;
            end else if (data_we && (sel_q == SEL_W'(g))) begin
                level[g] <= wr_byte;
            end
        end
    end

    assign rd_value = level[sel_q];

    // R5: registers move only on a data strobe
    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> $stable(level));

    // R4: logic outputs follow command bits 4 and 3
    p_gpo_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_we |=> (gpo == {$past(wr_byte[INS_O2_BIT]), $past(wr_byte[INS_O1_BIT])}));

    // R4: logic outputs hold between command bytes
    p_gpo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_we |=> $stable(gpo));
endmodule

// File: rtl/twsr_bus_fsm.sv
module twsr_bus_fsm
    import twsr_pkg::*;
#(
    parameter int                   ADDR_HI_W = 5,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI   = 5'b01011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               sda_rise,
    input  logic               sda_fall,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_value,
    output logic               instr_we,
    output logic               data_we,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               sda_pull_low
);
    localparam int              CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    bus_state_t        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_q;
    logic              mack_q;
    logic              pull_q;

    logic ev_start, ev_stop, byte_end, addr_hit;

    assign ev_start = sda_fall & scl_lvl;
    assign ev_stop  = sda_rise & scl_lvl;
    assign byte_end = scl_fall & (bit_cnt == FULL);
    assign addr_hit = (shreg[BYTE_W-1:1] == {ADDR_HI, strap});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (ev_stop) begin
            state_nx = ST_IDLE;
        end else if (ev_start) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_end) state_nx = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rw_q ? ST_RD_BYTE : ST_INSTR;
                ST_INSTR:     if (byte_end) state_nx = ST_INSTR_ACK;
                ST_INSTR_ACK: if (scl_fall) state_nx = ST_WR_BYTE;
                ST_WR_BYTE:   if (byte_end) state_nx = ST_WR_ACK;
                ST_WR_ACK:    if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:   if (byte_end) state_nx = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_nx = mack_q ? ST_RD_BYTE : ST_SKIP;
                ST_SKIP:      state_nx = ST_SKIP;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Output and datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            pull_q  <= 1'b0;
        end else if (ev_stop || ev_start) begin
            bit_cnt <= '0;
            pull_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_INSTR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_end) begin
                        pull_q <= (state != ST_ADDR) || addr_hit;
                        if (state == ST_ADDR) rw_q <= shreg[0];
                    end
                end
                ST_ADDR_ACK, ST_INSTR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR_ACK && rw_q) begin
                            shreg  <= rd_value;
                            pull_q <= ~rd_value[BYTE_W-1];
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                    if (scl_fall) begin
                        if (bit_cnt == FULL) begin
                            pull_q <= 1'b0;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            pull_q <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_lvl;
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mack_q) begin
                            shreg  <= rd_value;
                            pull_q <= ~rd_value[BYTE_W-1];
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                ST_IDLE, ST_SKIP: pull_q <= 1'b0;
                default:          pull_q <= 1'b0;
            endcase
        end
    end

    assign instr_we     = (state == ST_INSTR)   && byte_end;
    assign data_we      = (state == ST_WR_BYTE) && byte_end;
    assign rx_byte      = shreg;
    assign sda_pull_low = pull_q;

    // R3: the target moves the data line only while the clock is low
    p_pull_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_q != $past(pull_q)) |-> !scl_lvl);

    // R9: idle means the line is released
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !pull_q);

    // R2: an unaddressed or finished target stays silent
    p_quiet_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !pull_q);

    // R2: a mismatching address is never acknowledged
    p_no_ack_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR) && byte_end && !addr_hit) |=> !pull_q);
endmodule

// File: rtl/twin_setting_i2c_target.sv
module twin_setting_i2c_target
    import twsr_pkg::*;
#(
    parameter int                   ADDR_HI_W   = 5,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI     = 5'b01011,
    parameter logic [BYTE_W-1:0]    RESET_LEVEL = 8'h80,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull_low,
    output logic [BYTE_W-1:0]  level_a,
    output logic [BYTE_W-1:0]  level_b,
    output logic               gpo_1,
    output logic               gpo_2
);
    logic [NUM_LINES-1:0]          ln_lvl, ln_rise, ln_fall;
    logic                          instr_we, data_we;
    logic [BYTE_W-1:0]             rx_byte, rd_value;
    logic [NUM_CH-1:0][BYTE_W-1:0] level;
    logic [1:0]                    gpo;

    twsr_line_sync #(
        .LINES  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_in, scl_in}),
        .lvl   (ln_lvl),
        .rise  (ln_rise),
        .fall  (ln_fall)
    );

    twsr_bus_fsm #(
        .ADDR_HI_W (ADDR_HI_W),
        .ADDR_HI   (ADDR_HI)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl      (ln_lvl[LINE_SCL]),
        .scl_rise     (ln_rise[LINE_SCL]),
        .scl_fall     (ln_fall[LINE_SCL]),
        .sda_lvl      (ln_lvl[LINE_SDA]),
        .sda_rise     (ln_rise[LINE_SDA]),
        .sda_fall     (ln_fall[LINE_SDA]),
        .strap        (strap),
        .rd_value     (rd_value),
        .instr_we     (instr_we),
        .data_we      (data_we),
        .rx_byte      (rx_byte),
        .sda_pull_low (sda_pull_low)
    );

    twsr_chan_bank #(
        .RESET_LEVEL (RESET_LEVEL)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_we (instr_we),
        .data_we  (data_we),
        .wr_byte  (rx_byte),
        .level    (level),
        .gpo      (gpo),
        .rd_value (rd_value)
    );

    assign level_a = level[0];
    assign level_b = level[1];
    assign gpo_1   = gpo[0];
    assign gpo_2   = gpo[1];
endmodule

// File: tb/twin_setting_i2c_target_test.sv
module twin_setting_i2c_target_test;
    localparam int Q = 10;   // quarter bus bit, in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_pull_low;
    logic [7:0] level_a, level_b;
    logic       gpo_1, gpo_2;
    logic       sda_bus;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_bus = m_sda & ~sda_pull_low;

    twin_setting_i2c_target uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_bus),
        .strap        (strap),
        .sda_pull_low (sda_pull_low),
        .level_a      (level_a),
        .level_b      (level_b),
        .gpo_1        (gpo_1),
        .gpo_2        (gpo_2)
    );

    typedef struct {
        string req;
        int    val;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int    obs_val;
    event  obs_ev;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Scoreboard monitor: pops one expectation per observation.
    initial begin
        forever begin
            @(obs_ev);
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected observation: actual 0x%0h expected none", obs_val);
            end else begin
                cur = exp_q.pop_front();
                if (cur.val != obs_val) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", cur.req, obs_val, cur.val);
                end
            end
        end
    end

    task automatic push_exp(input string req, input int val);
        item_t it;
        it.req = req;
        it.val = val;
        exp_q.push_back(it);
    endtask

    task automatic observe(input int val);
        obs_val = val;
        ->obs_ev;
        #1;
    endtask

    task automatic qwait();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    // Sends a byte and reports whether the target acknowledged it.
    task automatic send_byte(input logic [7:0] b);
        bit acked;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait();
            m_scl = 1'b1; qwait(); qwait();
            m_scl = 1'b0; qwait();
        end
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        acked = !sda_bus;
        qwait();
        m_scl = 1'b0; qwait();
        observe(int'(acked));
    endtask

    // Reads a byte, then sends ACK (give_ack=1) or NACK.
    task automatic recv_byte(input bit give_ack);
        logic [7:0] b;
        b = '0;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            m_scl = 1'b1; qwait();
            b[i] = sda_bus;
            qwait();
            m_scl = 1'b0; qwait();
        end
        m_sda = give_ack ? 1'b0 : 1'b1; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
        observe(int'(b));
    endtask

    task automatic check_port(input string req, input int act, input int expv);
        push_exp(req, expv);
        observe(act);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        check_port("R1 pull", int'(sda_pull_low), 0);
        check_port("R1 level_a", int'(level_a), 8'h80);
        check_port("R1 level_b", int'(level_b), 8'h80);
        check_port("R1 gpo", int'({gpo_2, gpo_1}), 0);
        rst_n = 1'b1;
        qwait();

        // Write channel 1: command 0x90 (ch1, O1=1, O2=0), two data bytes
        bus_start();
        push_exp("R2 addr ack", 1); send_byte(8'h5C);
        push_exp("R3 cmd ack", 1);  send_byte(8'h90);
        check_port("R4 gpo after cmd", int'({gpo_2, gpo_1}), 2'b01);
        push_exp("R3 data ack", 1); send_byte(8'h3C);
        check_port("R5 level_b", int'(level_b), 8'h3C);
        check_port("R5 level_a untouched", int'(level_a), 8'h80);
        push_exp("R3 data ack 2", 1); send_byte(8'h7E);
        check_port("R5 level_b rewrite", int'(level_b), 8'h7E);
        bus_stop();

        // Read back channel 1
        bus_start();
        push_exp("R6 read addr ack", 1); send_byte(8'h5D);
        push_exp("R6 read data", 8'h7E); recv_byte(1'b0);
        bus_stop();
        qwait();
        check_port("R9 released after stop", int'(sda_pull_low), 0);

        // Foreign address (strap 00): nothing acknowledged or changed
        bus_start();
        push_exp("R2 foreign addr nack", 0); send_byte(8'h58);
        push_exp("R2 foreign cmd nack", 0);  send_byte(8'h18);
        push_exp("R2 foreign data nack", 0); send_byte(8'h11);
        bus_stop();
        check_port("R2 level_a kept", int'(level_a), 8'h80);
        check_port("R2 level_b kept", int'(level_b), 8'h7E);
        check_port("R2 gpo kept", int'({gpo_2, gpo_1}), 2'b01);

        // Command-only write: 0x6F -> ch0, O1=0, O2=1, reserved/low bits set
        bus_start();
        push_exp("R2 addr ack", 1);  send_byte(8'h5C);
        push_exp("R3 cmd ack", 1);   send_byte(8'h6F);
        bus_stop();
        check_port("R4 gpo masked bits", int'({gpo_2, gpo_1}), 2'b10);
        check_port("R7 level_a unchanged", int'(level_a), 8'h80);
        check_port("R7 level_b unchanged", int'(level_b), 8'h7E);

        // Read now returns channel 0; ACK then NACK
        bus_start();
        push_exp("R7 read addr ack", 1); send_byte(8'h5D);
        push_exp("R7 read ch0", 8'h80);  recv_byte(1'b1);
        push_exp("R8 second byte", 8'h80); recv_byte(1'b0);
        check_port("R8 released after nack", int'(sda_pull_low), 0);
        bus_stop();

        // Write ch0 then repeated START into a read
        bus_start();
        push_exp("R2 addr ack", 1);  send_byte(8'h5C);
        push_exp("R3 cmd ack", 1);   send_byte(8'h10);
        push_exp("R3 data ack", 1);  send_byte(8'h33);
        check_port("R5 level_a", int'(level_a), 8'h33);
        bus_start();
        push_exp("R10 restart addr ack", 1); send_byte(8'h5D);
        push_exp("R10 read after restart", 8'h33); recv_byte(1'b0);
        bus_stop();
        check_port("R4 gpo after 0x10", int'({gpo_2, gpo_1}), 2'b01);

        // Bytes clocked without a START after STOP are ignored
        m_scl = 1'b0; qwait();
        push_exp("R9 no start no ack", 0); send_byte(8'h5C);
        push_exp("R9 no start no ack 2", 0); send_byte(8'h00);
        bus_stop();
        check_port("R9 level_a kept", int'(level_a), 8'h33);

        // Strap change: new address accepted, old one refused
        strap = 2'b01;
        qwait();
        bus_start();
        push_exp("R2 strap 01 ack", 1); send_byte(8'h5A);
        push_exp("R3 cmd ack", 1);      send_byte(8'h80);
        push_exp("R3 data ack", 1);     send_byte(8'hC3);
        bus_stop();
        check_port("R5 level_b strap", int'(level_b), 8'hC3);
        check_port("R4 gpo cleared", int'({gpo_2, gpo_1}), 2'b00);
        bus_start();
        push_exp("R2 old addr refused", 0); send_byte(8'h5C);
        bus_stop();
        check_port("R2 level_b kept", int'(level_b), 8'hC3);

        #1;
        while (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            n_run++;
            n_fail++;
            $display("FAIL %s: actual none expected 0x%0h", cur.req, cur.val);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule